// File: doc/BRIEF.md
# Stacked-Die Scan Test Access Router

This block steers scan test data for a two-die stack bonded face-to-back, where each die carries one scan-testable module. A registered access mode picks the source and sink of each scan chain. The choices are the shared functional pads, dedicated probe pads on the back side of the lower die, dedicated probe pads on the front side of the upper die, the board-level test pins, or the vertical through-silicon links to the other die. The mode follows the test stage of the part: lower die probed before thinning, lower die probed after thinning, upper die probed on its own, stack test, and board test.

In every mode except board test, the router exposes two chains. Chain 0 is the wrapper boundary register. Chain 1 is the internal scan path, formed by stitching the die's internal chains end to end. The router also chooses whether the lower die's external-interface boundary segment joins chain 0. It puts the boundary registers into drive and capture roles when the die-to-die links are under test. When no upper die is present, it folds the upward path back so that scan-out comes from the local end.

Top module: `stack_scan_router`

## Requirements
- R1: After reset the mode is board test (code 4). In board test the board input feeds the external-interface segment, the board output returns that segment's end, and every other scan output and chain input is 0.
- R2: The mode (3 bits, codes 0..4) and the stack sub-mode (2 bits) are loaded at a clock edge only while the update strobe or the test-reset strobe is high. At any other edge, changes on the mode inputs have no effect on routing.
- R3: Code 0, lower die before thinning: pad input 0 drives the core boundary segment and pad output 0 returns its end. Pad input 1 heads the lower internal path and pad output 1 returns its end. The external-interface segment input is held at 0.
- R4: In every mode, internal chain k of each die (k ≥ 1) is fed from the scan-out of chain k-1.
- R5: Code 1, lower die after thinning: back probe input 0 feeds the core segment, then the external-interface segment, then back probe output 0. Back probe input 1 heads the lower internal path, and back probe output 1 returns its end.
- R6: Code 2, upper die alone: front probe inputs 0 and 1 head the upper boundary register and upper internal path, and front probe outputs 0 and 1 return their ends. This mode does not depend on the upper-die-present input.
- R7: Code 3, sub-mode 0 (lower): the pads drive the lower chains as in R5, with the pads in place of the back probes.
- R8: Code 3, sub-mode 1 (upper), with an upper die present: pad inputs travel up the vertical links to head the upper chains, and pad outputs return the upper chain ends.
- R9: Code 3, sub-mode 2 (link test): pad input 0 feeds the lower core segment, whose end drives the upper boundary register, whose end returns on pad output 0. Chain 1 is the lower internal path. The lower boundary drive flag is high. The upper capture flag is high when an upper die is present.
- R10: With no upper die present, in sub-modes 1 and 2 the upper chain heads are 0. In sub-mode 1 pad outputs equal pad inputs. In sub-mode 2 pad output 0 returns the lower core segment end.
- R11: In code 4 only the board pins carry scan data. The pad and probe outputs are 0, and neither drive flag is set.
- R12: A load with a mode code of 5..7, or with code 3 and sub-mode 3, is ignored, and the previous mode remains in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_strobe | input | 1 | Mode update strobe |
| tst_rst | input | 1 | Test-reset strobe, also loads the mode |
| mode_in | input | 3 | Requested access mode code |
| sub_in | input | 2 | Requested stack sub-mode |
| upper_present | input | 1 | High when an upper die is bonded |
| fpad_si | input | 2 | Shared functional pads used as scan-in (bit 0 boundary, bit 1 internal) |
| fpad_so | output | 2 | Shared functional pads used as scan-out |
| bprobe_si | input | 2 | Lower-die back-side probe scan-in |
| bprobe_so | output | 2 | Lower-die back-side probe scan-out |
| tprobe_si | input | 2 | Upper-die front-side probe scan-in |
| tprobe_so | output | 2 | Upper-die front-side probe scan-out |
| brd_tdi | input | 1 | Board test data in |
| brd_tdo | output | 1 | Board test data out |
| bot_core_si | output | 1 | Lower die core-side boundary segment input |
| bot_core_so | input | 1 | Lower die core-side boundary segment end |
| bot_ext_si | output | 1 | Lower die external-interface segment input |
| bot_ext_so | input | 1 | Lower die external-interface segment end |
| bot_int_si | output | NCH | Lower die internal chain inputs |
| bot_int_so | input | NCH | Lower die internal chain ends |
| top_wbr_si | output | 1 | Upper die boundary register input |
| top_wbr_so | input | 1 | Upper die boundary register end |
| top_int_si | output | NCH | Upper die internal chain inputs |
| top_int_so | input | NCH | Upper die internal chain ends |
| bot_bsr_drive | output | 1 | Lower boundary cells drive the links |
| top_bsr_capture | output | 1 | Upper boundary cells capture from the links |

## Verification
Two things can happen in the same cycle: a mode load, and a change in the routing inputs, including the upper-die-present flag. The bench provokes this by raising a strobe in the same cycle that it changes mode_in, sub_in, upper_present and all chain data. Some of those loads carry illegal codes. Others change mode_in with no strobe at all. After the edge, the routed outputs are compared with a bench model that updates its mode only on a legal strobed load. Any mode that is taken early, taken late, or wrongly accepted therefore shows up as misrouted scan data.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    AM_PRETHIN   = 3'd0,
    AM_POSTTHIN  = 3'd1,
    AM_TOPPROBE  = 3'd2,
    AM_STACK     = 3'd3,
    AM_BOARD     = 3'd4
  } acc_mode_e;

  typedef enum logic [1:0] {
    SM_LOWER = 2'd0,
    SM_UPPER = 2'd1,
    SM_LINK  = 2'd2
  } sub_mode_e;

  // A requested code pair is accepted only if it names a defined mode.
  function automatic logic code_ok(input logic [2:0] m, input logic [1:0] s);
    return (m <= 3'd4) && !((m == 3'd3) && (s == 2'd3));
  endfunction

endpackage

// File: rtl/ssr_mode_reg.sv
module ssr_mode_reg
  import ssr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_strobe,
  input  logic      tst_rst,
  input  logic [2:0] mode_in,
  input  logic [1:0] sub_in,
  output acc_mode_e mode_q,
  output sub_mode_e sub_q,
  output logic      load_ev
);

  assign load_ev = (upd_strobe | tst_rst) & code_ok(mode_in, sub_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_BOARD;
      sub_q  <= SM_LOWER;
    end else if (load_ev) begin
      mode_q <= acc_mode_e'(mode_in);
      sub_q  <= (mode_in == 3'd3) ? sub_mode_e'(sub_in) : SM_LOWER;
    end
  end

endmodule

// File: rtl/ssr_int_concat.sv
module ssr_int_concat #(
  parameter int NCH = 4
) (
  input  logic           head,
  input  logic [NCH-1:0] so,
  output logic [NCH-1:0] si,
  output logic           tail
);

  for (genvar k = 0; k < NCH; k++) begin : g_link
    if (k == 0) begin : g_first
      assign si[k] = head;
    end else begin : g_next
      assign si[k] = so[k-1];
    end
  end

  assign tail = so[NCH-1];

endmodule

// File: rtl/ssr_route.sv
module ssr_route
  import ssr_pkg::*;
(
  input  acc_mode_e  mode_q,
  input  sub_mode_e  sub_q,
  input  logic       upper_present,
  input  logic [1:0] fpad_si,
  input  logic [1:0] bprobe_si,
  input  logic [1:0] tprobe_si,
  input  logic       brd_tdi,
  input  logic       bot_core_so,
  input  logic       bot_ext_so,
  input  logic       bot_int_tail,
  input  logic       top_wbr_so,
  input  logic       top_int_tail,
  output logic [1:0] fpad_so,
  output logic [1:0] bprobe_so,
  output logic [1:0] tprobe_so,
  output logic       brd_tdo,
  output logic       bot_core_si,
  output logic       bot_ext_si,
  output logic       bot_int_head,
  output logic       top_wbr_si,
  output logic       top_int_head,
  output logic       bot_bsr_drive,
  output logic       top_bsr_capture
);

  logic [1:0] tsv_up;
  logic [1:0] tsv_dn;
  logic       top_from_probe;
  logic       top_from_tsv;

  // Upward link and upper-die source selection.
  always_comb begin
    tsv_up         = 2'b00;
    top_from_probe = (mode_q == AM_TOPPROBE);
    top_from_tsv   = 1'b0;
    if (mode_q == AM_STACK) begin
      if (sub_q == SM_UPPER) begin
        tsv_up       = fpad_si;
        top_from_tsv = 1'b1;
      end else if (sub_q == SM_LINK) begin
        tsv_up       = {1'b0, bot_core_so};
        top_from_tsv = 1'b1;
      end
    end
  end

  // Upper die local access: probe pads or links from below.
  always_comb begin
    top_wbr_si   = 1'b0;
    top_int_head = 1'b0;
    tprobe_so    = 2'b00;
    tsv_dn       = 2'b00;
    if (top_from_probe) begin
      top_wbr_si   = tprobe_si[0];
      top_int_head = tprobe_si[1];
      tprobe_so    = {top_int_tail, top_wbr_so};
    end else if (top_from_tsv && upper_present) begin
      top_wbr_si   = tsv_up[0];
      top_int_head = tsv_up[1];
      tsv_dn       = {top_int_tail, top_wbr_so};
    end
  end

  // Lower die routing and return paths.
  always_comb begin
    fpad_so         = 2'b00;
    bprobe_so       = 2'b00;
    brd_tdo         = 1'b0;
    bot_core_si     = 1'b0;
    bot_ext_si      = 1'b0;
    bot_int_head    = 1'b0;
    bot_bsr_drive   = 1'b0;
    top_bsr_capture = 1'b0;
    unique case (mode_q)
      AM_PRETHIN: begin
        bot_core_si  = fpad_si[0];
        bot_int_head = fpad_si[1];
        fpad_so      = {bot_int_tail, bot_core_so};
      end
      AM_POSTTHIN: begin
        bot_core_si  = bprobe_si[0];
        bot_ext_si   = bot_core_so;
        bot_int_head = bprobe_si[1];
        bprobe_so    = {bot_int_tail, bot_ext_so};
      end
      AM_TOPPROBE: begin
      end
      AM_STACK: begin
        case (sub_q)
          SM_LOWER: begin
            bot_core_si  = fpad_si[0];
            bot_ext_si   = bot_core_so;
            bot_int_head = fpad_si[1];
            fpad_so      = {bot_int_tail, bot_ext_so};
          end
          SM_UPPER: begin
            fpad_so = upper_present ? tsv_dn : tsv_up;
          end
          SM_LINK: begin
            bot_core_si     = fpad_si[0];
            bot_int_head    = fpad_si[1];
            fpad_so         = {bot_int_tail, upper_present ? tsv_dn[0] : tsv_up[0]};
            bot_bsr_drive   = 1'b1;
            top_bsr_capture = upper_present;
          end
          default: begin
          end
        endcase
      end
      AM_BOARD: begin
        bot_ext_si = brd_tdi;
        brd_tdo    = bot_ext_so;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/stack_scan_router.sv
module stack_scan_router
  import ssr_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_strobe,
  input  logic           tst_rst,
  input  logic [2:0]     mode_in,
  input  logic [1:0]     sub_in,
  input  logic           upper_present,
  input  logic [1:0]     fpad_si,
  output logic [1:0]     fpad_so,
  input  logic [1:0]     bprobe_si,
  output logic [1:0]     bprobe_so,
  input  logic [1:0]     tprobe_si,
  output logic [1:0]     tprobe_so,
  input  logic           brd_tdi,
  output logic           brd_tdo,
  output logic           bot_core_si,
  input  logic           bot_core_so,
  output logic           bot_ext_si,
  input  logic           bot_ext_so,
  output logic [NCH-1:0] bot_int_si,
  input  logic [NCH-1:0] bot_int_so,
  output logic           top_wbr_si,
  input  logic           top_wbr_so,
  output logic [NCH-1:0] top_int_si,
  input  logic [NCH-1:0] top_int_so,
  output logic           bot_bsr_drive,
  output logic           top_bsr_capture
);

  acc_mode_e mode_q;
  sub_mode_e sub_q;
  logic      load_ev;
  logic      bot_int_head, bot_int_tail;
  logic      top_int_head, top_int_tail;

  ssr_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_strobe (upd_strobe),
    .tst_rst    (tst_rst),
    .mode_in    (mode_in),
    .sub_in     (sub_in),
    .mode_q     (mode_q),
    .sub_q      (sub_q),
    .load_ev    (load_ev)
  );

  ssr_route u_route (
    .mode_q          (mode_q),
    .sub_q           (sub_q),
    .upper_present   (upper_present),
    .fpad_si         (fpad_si),
    .bprobe_si       (bprobe_si),
    .tprobe_si       (tprobe_si),
    .brd_tdi         (brd_tdi),
    .bot_core_so     (bot_core_so),
    .bot_ext_so      (bot_ext_so),
    .bot_int_tail    (bot_int_tail),
    .top_wbr_so      (top_wbr_so),
    .top_int_tail    (top_int_tail),
    .fpad_so         (fpad_so),
    .bprobe_so       (bprobe_so),
    .tprobe_so       (tprobe_so),
    .brd_tdo         (brd_tdo),
    .bot_core_si     (bot_core_si),
    .bot_ext_si      (bot_ext_si),
    .bot_int_head    (bot_int_head),
    .top_wbr_si      (top_wbr_si),
    .top_int_head    (top_int_head),
    .bot_bsr_drive   (bot_bsr_drive),
    .top_bsr_capture (top_bsr_capture)
  );

  ssr_int_concat #(.NCH(NCH)) u_bot_int (
    .head (bot_int_head),
    .so   (bot_int_so),
    .si   (bot_int_si),
    .tail (bot_int_tail)
  );

  ssr_int_concat #(.NCH(NCH)) u_top_int (
    .head (top_int_head),
    .so   (top_int_so),
    .si   (top_int_si),
    .tail (top_int_tail)
  );

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           upd_strobe,
  input logic           tst_rst,
  input logic [2:0]     mode_q,
  input logic           upper_present,
  input logic [1:0]     fpad_so,
  input logic [1:0]     tprobe_si,
  input logic           brd_tdi,
  input logic           brd_tdo,
  input logic           bot_core_so,
  input logic           bot_ext_si,
  input logic           bot_ext_so,
  input logic [NCH-1:0] bot_int_si,
  input logic [NCH-1:0] bot_int_so,
  input logic           top_wbr_si,
  input logic           top_wbr_so,
  input logic [NCH-1:0] top_int_si,
  input logic           bot_bsr_drive
);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_strobe && !tst_rst) |=> $stable(mode_q));

  // R12
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= 3'd4);

  // R11
  board_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4) |-> (brd_tdo == bot_ext_so && bot_ext_si == brd_tdi));

  // R3
  prethin_ext_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0) |-> (bot_ext_si == 1'b0));

  // R4
  int_concat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bot_int_si[NCH-1:1] == bot_int_so[NCH-2:0]);

  // R6
  top_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2) |-> (top_wbr_si == tprobe_si[0] && top_int_si[0] == tprobe_si[1]));

  // R10
  no_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upper_present && mode_q != 3'd2) |-> (top_wbr_si == 1'b0 && top_int_si[0] == 1'b0));

  // R9
  link_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bot_bsr_drive |-> (fpad_so[0] == (upper_present ? top_wbr_so : bot_core_so)));

endmodule

bind stack_scan_router ssr_checker #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .upd_strobe    (upd_strobe),
  .tst_rst       (tst_rst),
  .mode_q        (mode_q),
  .upper_present (upper_present),
  .fpad_so       (fpad_so),
  .tprobe_si     (tprobe_si),
  .brd_tdi       (brd_tdi),
  .brd_tdo       (brd_tdo),
  .bot_core_so   (bot_core_so),
  .bot_ext_si    (bot_ext_si),
  .bot_ext_so    (bot_ext_so),
  .bot_int_si    (bot_int_si),
  .bot_int_so    (bot_int_so),
  .top_wbr_si    (top_wbr_si),
  .top_wbr_so    (top_wbr_so),
  .top_int_si    (top_int_si),
  .bot_bsr_drive (bot_bsr_drive)
);

// File: tb/stack_scan_router_bench.sv
module stack_scan_router_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 12 + 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         upd_strobe = 1'b0;
  logic         tst_rst = 1'b0;
  logic [2:0]   mode_in = 3'd0;
  logic [1:0]   sub_in = 2'd0;
  logic         upper_present = 1'b1;
  logic [1:0]   fpad_si = 2'b00;
  logic [1:0]   fpad_so;
  logic [1:0]   bprobe_si = 2'b00;
  logic [1:0]   bprobe_so;
  logic [1:0]   tprobe_si = 2'b00;
  logic [1:0]   tprobe_so;
  logic         brd_tdi = 1'b0;
  logic         brd_tdo;
  logic         bot_core_si;
  logic         bot_core_so = 1'b0;
  logic         bot_ext_si;
  logic         bot_ext_so = 1'b0;
  logic [N-1:0] bot_int_si;
  logic [N-1:0] bot_int_so = '0;
  logic         top_wbr_si;
  logic         top_wbr_so = 1'b0;
  logic [N-1:0] top_int_si;
  logic [N-1:0] top_int_so = '0;
  logic         bot_bsr_drive;
  logic         top_bsr_capture;

  int  n_cmp = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  int  m_mode = 4;
  int  m_sub = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_scan_router #(.NCH(N)) u_stack_scan_router (
    .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .tst_rst(tst_rst),
    .mode_in(mode_in), .sub_in(sub_in), .upper_present(upper_present),
    .fpad_si(fpad_si), .fpad_so(fpad_so), .bprobe_si(bprobe_si), .bprobe_so(bprobe_so),
    .tprobe_si(tprobe_si), .tprobe_so(tprobe_so), .brd_tdi(brd_tdi), .brd_tdo(brd_tdo),
    .bot_core_si(bot_core_si), .bot_core_so(bot_core_so),
    .bot_ext_si(bot_ext_si), .bot_ext_so(bot_ext_so),
    .bot_int_si(bot_int_si), .bot_int_so(bot_int_so),
    .top_wbr_si(top_wbr_si), .top_wbr_so(top_wbr_so),
    .top_int_si(top_int_si), .top_int_so(top_int_so),
    .bot_bsr_drive(bot_bsr_drive), .top_bsr_capture(top_bsr_capture)
  );

  function automatic bit legal(input int m, input int s);
    if (m > 4) return 1'b0;
    if (m == 3 && s == 3) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tag_of();
    case (m_mode)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: begin
        if (m_sub == 0) return "R7";
        if (!upper_present) return "R10";
        return (m_sub == 1) ? "R8" : "R9";
      end
      default: return "R11";
    endcase
  endfunction

  // Expected port picture from the requirements.
  function automatic logic [W-1:0] expect_obs();
    logic [1:0] efp, ebp, etp;
    logic etdo, ecore, eext, bhead, twbr, thead, edrv, ecap;
    {efp, ebp, etp} = '0;
    {etdo, ecore, eext, bhead, twbr, thead, edrv, ecap} = '0;
    if (m_mode == 0) begin
      ecore = fpad_si[0]; bhead = fpad_si[1];
      efp = {bot_int_so[N-1], bot_core_so};
    end else if (m_mode == 1) begin
      ecore = bprobe_si[0]; eext = bot_core_so; bhead = bprobe_si[1];
      ebp = {bot_int_so[N-1], bot_ext_so};
    end else if (m_mode == 2) begin
      twbr = tprobe_si[0]; thead = tprobe_si[1];
      etp = {top_int_so[N-1], top_wbr_so};
    end else if (m_mode == 3 && m_sub == 0) begin
      ecore = fpad_si[0]; eext = bot_core_so; bhead = fpad_si[1];
      efp = {bot_int_so[N-1], bot_ext_so};
    end else if (m_mode == 3 && m_sub == 1) begin
      if (upper_present) begin
        twbr = fpad_si[0]; thead = fpad_si[1];
        efp = {top_int_so[N-1], top_wbr_so};
      end else begin
        efp = fpad_si;
      end
    end else if (m_mode == 3) begin
      ecore = fpad_si[0]; bhead = fpad_si[1]; edrv = 1'b1; ecap = upper_present;
      if (upper_present) twbr = bot_core_so;
      efp = {bot_int_so[N-1], upper_present ? top_wbr_so : bot_core_so};
    end else begin
      eext = brd_tdi; etdo = bot_ext_so;
    end
    return {efp, ebp, etp, etdo, ecore, eext, {bot_int_so[N-2:0], bhead},
            twbr, {top_int_so[N-2:0], thead}, edrv, ecap};
  endfunction

  task automatic check(input string tag);
    logic [W-1:0] got, exp;
    string t;
    #2;
    t = (tag == "") ? tag_of() : tag;
    got = {fpad_so, bprobe_so, tprobe_so, brd_tdo, bot_core_si, bot_ext_si, bot_int_si,
           top_wbr_si, top_int_si, bot_bsr_drive, top_bsr_capture};
    exp = expect_obs();
    n_cmp++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d sub=%0d up=%0b got=%h expected=%h", t, m_mode, m_sub,
               upper_present, got, exp);
    end
    // R4: internal stitching of both dies
    n_cmp++;
    if (top_int_si[N-1:1] !== top_int_so[N-2:0]) begin
      n_fail++;
      $display("FAIL R4 top stitch got=%h expected=%h", top_int_si[N-1:1], top_int_so[N-2:0]);
    end
  endtask

  task automatic scramble();
    fpad_si = 2'($urandom); bprobe_si = 2'($urandom); tprobe_si = 2'($urandom);
    brd_tdi = 1'($urandom); bot_core_so = 1'($urandom); bot_ext_so = 1'($urandom);
    bot_int_so = N'($urandom); top_wbr_so = 1'($urandom); top_int_so = N'($urandom);
  endtask

  task automatic load(input int m, input int s, input bit via_rst);
    @(negedge clk);
    mode_in = 3'(m); sub_in = 2'(s);
    if (via_rst) tst_rst = 1'b1; else upd_strobe = 1'b1;
    if (legal(m, s)) begin m_mode = m; m_sub = (m == 3) ? s : 0; end
    @(negedge clk);
    upd_strobe = 1'b0; tst_rst = 1'b0;
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5A17);
    scramble();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1");  // reset lands in board test
    scramble(); check("R1");

    for (int up = 0; up < 2; up++) begin
      upper_present = up[0];
      for (int c = 0; c < 7; c++) begin
        int mm, ss;
        mm = (c < 3) ? c : ((c < 6) ? 3 : 4);
        ss = (c >= 3 && c < 6) ? c - 3 : 0;
        load(mm, ss, 1'b0);
        for (int p = 0; p < 3; p++) begin scramble(); check(""); end
      end
    end

    // R2: mode inputs move without a strobe
    upper_present = 1'b1;
    load(0, 0, 1'b0);
    @(negedge clk); mode_in = 3'd1; sub_in = 2'd2;
    repeat (3) @(negedge clk);
    scramble(); check("R2");
    load(1, 0, 1'b1);  // test-reset strobe also loads
    scramble(); check("R2");

    // R12: illegal codes leave the mode alone
    load(6, 0, 1'b0); scramble(); check("R12");
    load(3, 1, 1'b0);
    load(3, 3, 1'b0); scramble(); check("R12");
    load(7, 2, 1'b1); scramble(); check("R12");

    // Random: strobes, mode codes and data all change together
    for (int i = 0; i < 400; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom % 21);
      mode_in = 3'($urandom); sub_in = 2'($urandom);
      upd_strobe = (r % 3 == 0); tst_rst = (r % 7 == 0);
      upper_present = 1'($urandom);
      scramble();
      if ((upd_strobe || tst_rst) && legal(int'(mode_in), int'(sub_in))) begin
        m_mode = int'(mode_in); m_sub = (m_mode == 3) ? int'(sub_in) : 0;
      end
      @(negedge clk);
      upd_strobe = 1'b0; tst_rst = 1'b0;
      scramble();
      check("");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) got=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule